// File: doc/BRIEF.md
# Quad Byte SIMD Multiply Unit

This block runs one packed multiply instruction. It takes a 32-bit instruction word with a valid strobe and reads two 32-bit words from a sixteen-entry register file. It multiplies the four byte lanes of the first word by the matching byte lanes of the second word. A mode field chooses whether the bytes of the first word are signed or unsigned. The bytes of the second word are always unsigned.

Each product keeps its low 16 bits. The four products are packed into two words, and the two words go to two destination registers that the instruction names separately.

An enable bit in a separate control register gates every write the instruction makes. A preload port fills the register file. A combinational read port brings any register out so that its contents can be compared against a lane-by-lane computation.

Top module: `quad_byte_mul`

## Requirements
- R1: The instruction word is decoded as follows: destination A is bits 9:6, source B is bits 13:10, source C is bits 17:14, destination D is bits 21:18, and the mode is bits 23:22. All other bits are ignored.
- R2: When the mode equals 2, each byte of source B is a signed two's-complement value. For modes 0, 1 and 3, each byte of source B is unsigned.
- R3: Each byte of source C is unsigned in every mode.
- R4: Lane i covers bits 8i+7:8i. Destination D receives the low 16 bits of the lane 0 product in bits 15:0 and the low 16 bits of the lane 1 product in bits 31:16.
- R5: Destination A receives the lane 2 product in bits 15:0 and the lane 3 product in bits 31:16, with each product cut to 16 bits.
- R6: When destination A equals destination D, that register ends up holding the lane 2/3 word.
- R7: Both sources are read before any destination is written. A source that is also a destination therefore supplies its old value.
- R8: The control register is loaded from `ctl_wdata` when `ctl_we` is high. When its bit 0 is clear, an instruction changes no register.
- R9: Register 0 always reads as zero. Writes to it, from an instruction or from the preload port, are ignored.
- R10: The results of an instruction presented with `insn_valid` high are written at the next rising clock edge. `done` is high for exactly the cycle that follows that edge.
- R11: A synchronous active-high reset clears all registers, the control register and `done`.
- R12: A preload write stores `pre_data` into register `pre_idx` at the clock edge. When an instruction writes the same register at the same edge, the instruction's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| ctl_we | input | 1 | Control register load |
| ctl_wdata | input | 32 | Control register value (bit 0 = enable) |
| pre_we | input | 1 | Preload write strobe |
| pre_idx | input | 4 | Preload register index |
| pre_data | input | 32 | Preload data |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 32 | Read port data (combinational) |
| ctl_q | output | 32 | Current control register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main sweep runs every value of one byte of source B against a set of source C bytes that includes 0, 1, 0x7F, 0x80 and 0xFF, in all four modes. This separates mode 2 from the other three modes, and it separates signed from unsigned handling of source C. Distinct values in each lane expose swapped lanes and swapped halves. Directed cases cover aliased sources and destinations, equal destinations, destination 0, a cleared enable, and a preload that collides with an instruction write.

// File: rtl/quad_byte_mul.sv
module quad_byte_mul (
  input  logic        clk,
  input  logic        rst,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        pre_we,
  input  logic [3:0]  pre_idx,
  input  logic [31:0] pre_data,
  input  logic [3:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic [31:0] ctl_q,
  output logic        done
);
  localparam int NREG  = 16;
  localparam int LANES = 4;
  localparam int LW    = 8;
  localparam int PW    = 2 * LW;

  logic [31:0] rf [NREG];

  wire [3:0] dst_a  = insn[9:6];
  wire [3:0] src_b  = insn[13:10];
  wire [3:0] src_c  = insn[17:14];
  wire [3:0] dst_d  = insn[21:18];
  wire       sgn    = insn[23:22] == 2'd2;
  wire       unused_insn = &{1'b0, insn[31:24], insn[5:0]};

  wire [31:0] op_b = (src_b == 4'd0) ? 32'd0 : rf[src_b];
  wire [31:0] op_c = (src_c == 4'd0) ? 32'd0 : rf[src_c];

  logic [PW-1:0] prod [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [PW-1:0] eb = {{LW{sgn & op_b[LW*i+LW-1]}}, op_b[LW*i +: LW]};
    wire [PW-1:0] ec = {{LW{1'b0}}, op_c[LW*i +: LW]};
    assign prod[i] = eb * ec;
  end

  wire [31:0] word_d = {prod[1], prod[0]};
  wire [31:0] word_a = {prod[3], prod[2]};
  wire        wr     = insn_valid & ctl_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
      ctl_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= insn_valid;
      if (ctl_we) ctl_q <= ctl_wdata;
      if (pre_we && pre_idx != 4'd0) rf[pre_idx] <= pre_data;
      if (wr && dst_d != 4'd0) rf[dst_d] <= word_d;
      if (wr && dst_a != 4'd0) rf[dst_a] <= word_a;
    end
  end

  assign rd_data = (rd_idx == 4'd0) ? 32'd0 : rf[rd_idx];
endmodule

module quad_byte_mul_chk (
  input logic        clk,
  input logic        rst,
  input logic        insn_valid,
  input logic        ctl_we,
  input logic [31:0] ctl_wdata,
  input logic        pre_we,
  input logic [3:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic [31:0] ctl_q,
  input logic        done
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> done == $past(insn_valid));

  a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
    rd_idx == 4'd0 |-> rd_data == 32'd0);

  a_r8_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && !ctl_q[0] && !pre_we) |=> (!$stable(rd_idx) || $stable(rd_data)));

  a_r8_ctl_load: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ctl_q == $past(ctl_wdata));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (ctl_q == 32'd0 && !done));
endmodule

bind quad_byte_mul quad_byte_mul_chk u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .pre_we(pre_we), .rd_idx(rd_idx),
  .rd_data(rd_data), .ctl_q(ctl_q), .done(done)
);

// File: tb/quad_byte_mul_test.sv
`timescale 1ns/1ps
module quad_byte_mul_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        pre_we = 1'b0;
  logic [3:0]  pre_idx = '0;
  logic [31:0] pre_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] ctl_q;
  logic        done;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  quad_byte_mul uut (.*);

  function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] b,
                                     input logic [3:0] c, input logic [3:0] d,
                                     input logic [1:0] m);
    return {8'hA5, m, d, c, b, a, 6'h2B};
  endfunction

  function automatic logic [15:0] lp(input logic [7:0] x, input logic [7:0] y, input bit s);
    int sx;
    int p;
    sx = (s && x[7]) ? int'(x) - 256 : int'(x);
    p  = sx * int'(y);
    return p[15:0];
  endfunction

  function automatic logic [31:0] pk(input logic [31:0] b, input logic [31:0] c,
                                     input bit s, input bit hi);
    if (hi) return {lp(b[31:24], c[31:24], s), lp(b[23:16], c[23:16], s)};
    return {lp(b[15:8], c[15:8], s), lp(b[7:0], c[7:0], s)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdreg(input logic [3:0] i, output logic [31:0] v);
    rd_idx = i;
    #0.5;
    v = rd_data;
  endtask

  task automatic preload(input logic [3:0] i, input logic [31:0] v);
    pre_we = 1'b1; pre_idx = i; pre_data = v;
    @(posedge clk); @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input string tag);
    insn = w; insn_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    insn_valid = 1'b0;
    chk(tag, {31'd0, done}, 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, b, c, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    for (int i = 0; i < 16; i++) begin
      rdreg(4'(i), v);
      chk("R11 reg clear", v, 32'd0);
    end
    chk("R11 ctl clear", ctl_q, 32'd0);
    chk("R11 done clear", {31'd0, done}, 32'd0);

    // R8 disabled: no writes
    preload(4'd1, 32'h8182_FF7F);
    preload(4'd2, 32'h0203_FFFF);
    preload(4'd3, 32'h1111_1111);
    issue(mk(4'd3, 4'd1, 4'd2, 4'd4, 2'd2), "R10 done");
    rdreg(4'd3, v); chk("R8 no write A", v, 32'h1111_1111);
    rdreg(4'd4, v); chk("R8 no write D", v, 32'd0);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);

    ctl_we = 1'b1; ctl_wdata = 32'h0000_0001;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
    chk("R8 ctl load", ctl_q, 32'h1);

    // Sweep: R2 R3 R4 R5
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 5; k++) begin
          logic [7:0] cv;
          case (k)
            0: cv = 8'h00; 1: cv = 8'h01; 2: cv = 8'h7F; 3: cv = 8'h80; default: cv = 8'hFF;
          endcase
          b = {8'(a), 8'(a) ^ 8'h5A, ~8'(a), 8'(a + 1)};
          c = {cv ^ 8'h33, cv, ~cv, cv};
          preload(4'd1, b);
          preload(4'd2, c);
          issue(mk(4'd5, 4'd1, 4'd2, 4'd6, 2'(m)), "R10 sweep done");
          rdreg(4'd6, v);
          chk("R4 R2 R3 lanes0/1", v, pk(b, c, m == 2, 1'b0));
          rdreg(4'd5, v);
          chk("R5 R2 R3 lanes2/3", v, pk(b, c, m == 2, 1'b1));
        end
      end
    end

    // R1 other indices
    b = 32'hF00F_80C3; c = 32'h9ABC_DEF1;
    preload(4'd10, b); preload(4'd11, c);
    issue(mk(4'd9, 4'd10, 4'd11, 4'd12, 2'd2), "R1 done");
    rdreg(4'd12, v); chk("R1 dest D", v, pk(b, c, 1'b1, 1'b0));
    rdreg(4'd9, v);  chk("R1 dest A", v, pk(b, c, 1'b1, 1'b1));

    // R7 aliasing sources and destinations
    b = 32'h1234_5678; c = 32'h8899_AABB;
    preload(4'd7, b); preload(4'd8, c);
    issue(mk(4'd7, 4'd7, 4'd8, 4'd8, 2'd0), "R7 done");
    rdreg(4'd8, v); chk("R7 alias D", v, pk(b, c, 1'b0, 1'b0));
    rdreg(4'd7, v); chk("R7 alias A", v, pk(b, c, 1'b0, 1'b1));

    // R6 same destination
    b = 32'hFF80_7F01; c = 32'h0102_0304;
    preload(4'd1, b); preload(4'd2, c);
    issue(mk(4'd13, 4'd1, 4'd2, 4'd13, 2'd2), "R6 done");
    rdreg(4'd13, v); chk("R6 same dest", v, pk(b, c, 1'b1, 1'b1));

    // R9 destination 0 and preload of 0
    issue(mk(4'd0, 4'd1, 4'd2, 4'd14, 2'd2), "R9 done");
    rdreg(4'd14, v); chk("R9 other dest", v, pk(b, c, 1'b1, 1'b0));
    rdreg(4'd0, v);  chk("R9 reg0 after insn", v, 32'd0);
    preload(4'd0, 32'hDEAD_BEEF);
    rdreg(4'd0, v);  chk("R9 reg0 after preload", v, 32'd0);
    issue(mk(4'd3, 4'd0, 4'd2, 4'd4, 2'd0), "R9 src0 done");
    rdreg(4'd3, v);  chk("R9 src0 reads zero", v, 32'd0);

    // R12 collision: instruction wins
    pre_we = 1'b1; pre_idx = 4'd15; pre_data = 32'hCAFE_F00D;
    issue(mk(4'd3, 4'd1, 4'd2, 4'd15, 2'd1), "R12 done");
    pre_we = 1'b0;
    rdreg(4'd15, v); chk("R12 insn wins", v, pk(b, c, 1'b0, 1'b0));
    preload(4'd15, 32'hCAFE_F00D);
    rdreg(4'd15, v2); chk("R12 preload alone", v2, 32'hCAFE_F00D);

    // R11 reset again
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    rdreg(4'd15, v); chk("R11 reset reg", v, 32'd0);
    chk("R11 reset ctl", ctl_q, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule